// File: doc/BRIEF.md
# Dual-Output Maskable Interrupt Controller

This block gathers thirty-two single-cycle event pulses into a sticky flag set made of two 16-bit words and drives two interrupt request pins from that one shared set. Each pin sees the flags through its own 32-bit enable mask. The mask is held as two 16-bit words that line up bit for bit with the two flag words. Each pin also has a master enable and a polarity select. Software reads the flags, the masks, the control word and a per-pin "currently active" status over a simple word-wide register port. It acknowledges events by writing ones to the flag words.

Event line `k` lands in flag word `k/16`, bit `k%16`. The package names every line. The low word carries the line-quality and cycle-timing events: distortion, loss of signal, the two block starts, block end, phase zero, phase error, early, late and twice-missing sync, then the transmit and receive telegram start, end, wait and error events. The high word starts with eight service-channel events in bits 0 to 7. Above them are twice-missing receive, four timer-compare events, the divided-clock event, a programming fault and an address change. The register port is plain control: a write takes effect on the clock edge where `reg_we_i` is high, and a read is a combinational view of the word selected by `reg_addr_i`. No valid/ready handshake is needed because the port never stalls.

Register map (word addresses): 0 = flag word low, 1 = flag word high, 2/3 = pin 0 mask low/high, 4/5 = pin 1 mask low/high, 6 = control, 7 = status.

Top module: `irqc_dual_top`

## Requirements
- R1: An event pulse on `evt_i[k]` at a rising edge sets flag `k`, readable after that edge. The flag stays set on later cycles until a clear, and no flag sets without its event.
- R2: Writing to address 0 or 1 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R3: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: Pin `o` asserts only if at least one flag is set whose bit is also set in that pin's mask (pin 0 at addresses 2/3, pin 1 at addresses 4/5). A flag outside one pin's mask does not affect that pin.
- R5: With its master enable clear (control bit `2*o`), pin `o` stays inactive whatever the flags and masks hold.
- R6: With polarity bit `2*o+1` of the control word at 0, pin `o` is high when active and low when idle. With the bit at 1, the pin is low when active and high when idle.
- R7: Status (address 7) bit `o` reads 1 exactly while pin `o` is active. Writes to address 7 change nothing.
- R8: A pin's active state is registered. It changes one clock edge after the flag, mask or enable change that causes it.
- R9: After reset, all flags, masks and control bits are 0, both pins are low, and every register reads 0.
- R10: Event line `k` maps to flag word `k/16` bit `k%16`: lines 0–15 appear at address 0 and lines 16–31 at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one bit per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_o | output | 2 | Interrupt pins, level set by each pin's polarity |

## Verification
The hardest case to reach from the ports is a set and a clear of the same flag landing on one edge. The bench drives the event pulse and the clearing write in the same low clock phase, so that both are sampled by a single rising edge. The same write also clears a second, already-set flag to show that the clear itself worked. Beyond that, the bench walks every one of the 32 event lines. For each line it points pin 0's mask at that one bit and pin 1's mask at every other bit. This shows the word/bit placement, the per-pin masking, the one-edge output latency and the write-one clear for every line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Event line indices; line k lands in flag word k/16, bit k%16.
  localparam int unsigned EV_LINE_DISTORT   = 0;
  localparam int unsigned EV_LINE_NOSIGNAL  = 1;
  localparam int unsigned EV_BLK0_START     = 2;
  localparam int unsigned EV_BLK1_START     = 3;
  localparam int unsigned EV_BLK_END        = 4;
  localparam int unsigned EV_PHASE_ZERO     = 5;
  localparam int unsigned EV_PHASE_FAULT    = 6;
  localparam int unsigned EV_SYNC_EARLY     = 7;
  localparam int unsigned EV_SYNC_LATE      = 8;
  localparam int unsigned EV_SYNC_LOST2     = 9;
  localparam int unsigned EV_TX_BEGIN       = 10;
  localparam int unsigned EV_TX_DONE        = 11;
  localparam int unsigned EV_RX_AWAIT       = 12;
  localparam int unsigned EV_RX_BEGIN       = 13;
  localparam int unsigned EV_RX_DONE        = 14;
  localparam int unsigned EV_RX_FAULT       = 15;
  localparam int unsigned EV_SVC_BASE       = 16;  // eight service-channel lines
  localparam int unsigned EV_SVC_COUNT      = 8;
  localparam int unsigned EV_RX_LOST2       = 24;
  localparam int unsigned EV_TIMER_BASE     = 25;  // four timer-compare lines
  localparam int unsigned EV_TIMER_COUNT    = 4;
  localparam int unsigned EV_DIVCLK         = 29;
  localparam int unsigned EV_PROG_FAULT     = 30;
  localparam int unsigned EV_ADDR_CHANGE    = 31;

  // Register map helpers, derived from the flag word count and pin count.
  function automatic int unsigned mask_addr(int unsigned n_words, int unsigned pin,
                                            int unsigned word);
    return n_words + pin * n_words + word;
  endfunction

  function automatic int unsigned ctrl_addr(int unsigned n_words, int unsigned n_pins);
    return n_words * (1 + n_pins);
  endfunction
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] evt_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;

  // Clear first, then OR in events: a same-edge event wins over its clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_i) | evt_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned NUM_PINS  = 2,
  parameter int unsigned ADDR_W    = 3,
  localparam int unsigned FLAG_W   = WORD_W * NUM_WORDS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [WORD_W-1:0]          wdata_i,
  output logic [NUM_PINS*FLAG_W-1:0] mask_o,
  output logic [NUM_PINS-1:0]        en_o,
  output logic [NUM_PINS-1:0]        pol_o,
  output logic [FLAG_W-1:0]          clr_o
);
  localparam int unsigned CTRL_A = ctrl_addr(NUM_WORDS, NUM_PINS);

  // Write-one-to-clear strobes toward the flag bank.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
    assign clr_o[w*WORD_W +: WORD_W] =
      (we_i && addr_i == ADDR_W'(w)) ? wdata_i : '0;
  end

  // Per-pin mask words.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      localparam int unsigned MA = mask_addr(NUM_WORDS, p, w);
      logic [WORD_W-1:0] mask_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                mask_q <= '0;
        else if (we_i && addr_i == ADDR_W'(MA))     mask_q <= wdata_i;
      end
      assign mask_o[p*FLAG_W + w*WORD_W +: WORD_W] = mask_q;
    end

    // Control bits: 2p = master enable, 2p+1 = polarity.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[p]  <= 1'b0;
        pol_o[p] <= 1'b0;
      end else if (we_i && addr_i == ADDR_W'(CTRL_A)) begin
        en_o[p]  <= wdata_i[2*p];
        pol_o[p] <= wdata_i[2*p+1];
      end
    end
  end
endmodule

// File: rtl/irqc_out_unit.sv
module irqc_out_unit #(
  parameter int unsigned FLAG_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] mask_i,
  input  logic              en_i,
  input  logic              pol_i,
  output logic              active_o,
  output logic              pin_o
);
  logic active_q;

  // Registered so the pin never glitches on the wide OR.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= en_i && (|(flags_i & mask_i));
  end

  assign active_o = active_q;
  assign pin_o    = pol_i ? ~active_q : active_q;
endmodule

// File: rtl/irqc_dual_top.sv
module irqc_dual_top
  import irqc_pkg::*;
#(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned NUM_PINS  = 2,
  localparam int unsigned FLAG_W   = WORD_W * NUM_WORDS,
  localparam int unsigned STAT_A   = ctrl_addr(NUM_WORDS, NUM_PINS) + 1,
  localparam int unsigned ADDR_W   = $clog2(STAT_A + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [FLAG_W-1:0]   evt_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  output logic [NUM_PINS-1:0] irq_o
);
  localparam int unsigned CTRL_A = ctrl_addr(NUM_WORDS, NUM_PINS);

  logic [FLAG_W-1:0]          flags;
  logic [FLAG_W-1:0]          clr_vec;
  logic [NUM_PINS*FLAG_W-1:0] mask_flat;
  logic [NUM_PINS-1:0]        pin_en;
  logic [NUM_PINS-1:0]        pin_pol;
  logic [NUM_PINS-1:0]        pin_active;

  irqc_flag_bank #(.FLAG_W(FLAG_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  irqc_regfile #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_flat),
    .en_o    (pin_en),
    .pol_o   (pin_pol),
    .clr_o   (clr_vec)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_out
    irqc_out_unit #(.FLAG_W(FLAG_W)) u_out (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .flags_i  (flags),
      .mask_i   (mask_flat[p*FLAG_W +: FLAG_W]),
      .en_i     (pin_en[p]),
      .pol_i    (pin_pol[p]),
      .active_o (pin_active[p]),
      .pin_o    (irq_o[p])
    );
  end

  // Combinational read view.
  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (reg_addr_i == ADDR_W'(w)) reg_rdata_o = flags[w*WORD_W +: WORD_W];
    end
    for (int p = 0; p < NUM_PINS; p++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (reg_addr_i == ADDR_W'(mask_addr(NUM_WORDS, p, w)))
          reg_rdata_o = mask_flat[p*FLAG_W + w*WORD_W +: WORD_W];
      end
    end
    if (reg_addr_i == ADDR_W'(CTRL_A)) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        reg_rdata_o[2*p]   = pin_en[p];
        reg_rdata_o[2*p+1] = pin_pol[p];
      end
    end
    if (reg_addr_i == ADDR_W'(STAT_A)) begin
      for (int p = 0; p < NUM_PINS; p++) reg_rdata_o[p] = pin_active[p];
    end
  end
endmodule

// File: rtl/irqc_dual_checker.sv
module irqc_dual_checker #(
  parameter int unsigned FLAG_W   = 32,
  parameter int unsigned NUM_PINS = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [FLAG_W-1:0]          evt_i,
  input logic [FLAG_W-1:0]          flags,
  input logic [FLAG_W-1:0]          clr_vec,
  input logic [NUM_PINS*FLAG_W-1:0] mask_flat,
  input logic [NUM_PINS-1:0]        pin_en,
  input logic [NUM_PINS-1:0]        pin_pol,
  input logic [NUM_PINS-1:0]        pin_active,
  input logic [NUM_PINS-1:0]        irq_o
);
  p_evt_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags & $past(evt_i)) == $past(evt_i)));

  p_no_spurious_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(evt_i)) == '0));

  p_w1c_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags & $past(clr_vec & ~evt_i)) == '0));

  p_zero_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flags & ~clr_vec) & ~flags) == '0));

  p_set_beats_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags & $past(evt_i & clr_vec)) == $past(evt_i & clr_vec)));

  p_enable_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pin_active & ~$past(pin_en)) == '0));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    p_mask_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (!pin_active[p] ||
                (|($past(flags) & $past(mask_flat[p*FLAG_W +: FLAG_W])))));

    p_pin_steady_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($stable(pin_active[p]) && $stable(pin_pol[p])) |-> $stable(irq_o[p]));
  end
endmodule

bind irqc_dual_top irqc_dual_checker #(
  .FLAG_W   (FLAG_W),
  .NUM_PINS (NUM_PINS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .flags      (flags),
  .clr_vec    (clr_vec),
  .mask_flat  (mask_flat),
  .pin_en     (pin_en),
  .pin_pol    (pin_pol),
  .pin_active (pin_active),
  .irq_o      (irq_o)
);

// File: tb/irqc_dual_top_tb_top.sv
module irqc_dual_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_dual_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .evt_i       (evt),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(int k);
    @(negedge clk);
    evt = 32'h1 << k;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : main
    logic [15:0] v;
    logic [31:0] m;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R9: reset state of every register and both pins.
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R9 reg %0d after reset", a), 32'(v), 32'h0);
    end
    chk("R9 pins idle low", 32'(irq), 32'h0);

    // Both pins enabled, active-high.
    wr(3'd6, 16'h0005);

    // Sweep every event line: pin 0 masks only it, pin 1 masks all others.
    for (int b = 0; b < 32; b++) begin
      m = 32'h1 << b;
      wr(3'd2, m[15:0]);   wr(3'd3, m[31:16]);
      wr(3'd4, ~m[15:0]);  wr(3'd5, ~m[31:16]);
      pulse(b);
      rd(3'(b/16), v);
      chk($sformatf("R1 R10 line %0d flag word", b), 32'(v), 32'h1 << (b % 16));
      rd(3'(1 - b/16), v);
      chk($sformatf("R10 line %0d other word", b), 32'(v), 32'h0);
      chk($sformatf("R8 line %0d pins before latency edge", b), 32'(irq), 32'h0);
      step();
      rd(3'(b/16), v);
      chk($sformatf("R1 line %0d flag still set", b), 32'(v), 32'h1 << (b % 16));
      chk($sformatf("R4 line %0d pin0 only", b), 32'(irq), 32'h1);
      rd(3'd7, v);
      chk($sformatf("R7 line %0d status", b), 32'(v), 32'h1);
      wr(3'(b/16), 16'(32'h1 << (b % 16)));
      rd(3'(b/16), v);
      chk($sformatf("R2 line %0d cleared", b), 32'(v), 32'h0);
      step();
      chk($sformatf("R4 line %0d pins drop", b), 32'(irq), 32'h0);
    end

    // R2: writing zeros leaves flags alone.
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF);
    pulse(5); pulse(20);
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
    rd(3'd0, v); chk("R2 zero write keeps low word", 32'(v), 32'h0020);
    rd(3'd1, v); chk("R2 zero write keeps high word", 32'(v), 32'h0010);
    wr(3'd0, 16'hFFDF);
    rd(3'd0, v); chk("R2 clear of other bits only", 32'(v), 32'h0020);

    // R3: same-edge event on bit 3 and clear of bits 3 and 5.
    @(negedge clk);
    evt = 32'h8; we = 1'b1; addr = 3'd0; wdata = 16'h0028;
    @(negedge clk);
    evt = '0; we = 1'b0;
    rd(3'd0, v); chk("R3 set wins, other bit cleared", 32'(v), 32'h0008);

    // R5: master enable off keeps pins idle with flags and masks set.
    wr(3'd6, 16'h0000);
    step(); step();
    chk("R5 pins idle when disabled", 32'(irq), 32'h0);
    rd(3'd7, v); chk("R5 status idle when disabled", 32'(v), 32'h0);

    // R6: polarity, pin 0 active (bit 3 set, masked), pin 1 active too.
    wr(3'd6, 16'h0007);     // pin0 en, pol low-active; pin1 en, pol high-active
    step();
    chk("R6 pin0 active-low drives 0, pin1 drives 1", 32'(irq), 32'h2);
    wr(3'd6, 16'h000E);     // pin0 disabled low-active, pin1 en low-active
    step();
    chk("R6 idle low-active pin0 high, active low-active pin1 low", 32'(irq), 32'h1);
    rd(3'd6, v); chk("R6 control readback", 32'(v), 32'h000E);

    // R7: writes to status change nothing.
    wr(3'd7, 16'hFFFF);
    rd(3'd7, v); chk("R7 status after write", 32'(v), 32'h2);
    rd(3'd6, v); chk("R7 control untouched by status write", 32'(v), 32'h000E);

    // R8: mask change reaches the pin one edge later.
    wr(3'd6, 16'h0005);
    step();
    chk("R8 both active before mask change", 32'(irq), 32'h3);
    wr(3'd4, 16'h0000); wr(3'd5, 16'h0000);
    chk("R8 pin1 still active right after write", 32'(irq), 32'h3);
    step();
    chk("R8 pin1 idle one edge later", 32'(irq), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule